// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block drives the command bus of a low-latency DRAM from power-on to the point where normal traffic may start. It waits until both the power-good and clock-stable inputs are high. It then holds the bus in NOP for a minimum idle time, which is given in nanoseconds and turned into a cycle count using the clock period. After the idle time it sends a burst of mode-register writes on adjacent cycles. The first of these are dummies with an all-zero address, which reset the device logic. The last one carries the configured mode word.

After a settle delay it sends one auto-refresh to each of the eight banks in ascending order. It then pads the bus with NOPs until both the required NOP count and the row-cycle time have passed, and raises `init_done`. The flag stays high until reset. Commands appear on a one-hot command bus with a bank address, an address bus and an active-low chip-select.

Parameters: `CLK_PS` is the clock period in picoseconds and `IDLE_NS` is the minimum idle time. `N_DUMMY` is the number of dummy writes and must be at least 2. `T_MRSC` is the settle delay in cycles and must be at least 2. `T_RC` is the row-cycle time in cycles and `NOP_PAD` is the NOP count. `ADDR_W` is the address width. `BANKS` is the number of banks and defaults to 8.

Top module: `dram_init_seq`

## Requirements
- R1: While the block waits for power, `cmd` is NOP. It leaves the wait state on the first rising clock edge at which `pwr_good` and `clk_stable` are both high. One of them high alone does not start the sequence.
- R2: After that edge, exactly IDLE_CYC = ceil(IDLE_NS*1000/CLK_PS) cycles of NOP come before the first mode-register write.
- R3: The mode-register burst is N_DUMMY+1 writes on adjacent cycles. The last write drives `addr` equal to `mode_word`.
- R4: During every dummy write, `addr` and `bank` are all zeros.
- R5: The first auto-refresh comes exactly T_MRSC cycles after the valid mode write. Only NOPs appear in between.
- R6: Auto-refreshes go out on BANKS adjacent cycles with `bank` = 0, 1, ... BANKS-1 in ascending order, and `addr` is zero.
- R7: After the last auto-refresh there are PAD_LEN = max(NOP_PAD, T_RC) NOP cycles. `init_done` rises in the cycle that follows them.
- R8: Once `init_done` is high, it stays high and `cmd` stays NOP until reset.
- R9: Synchronous active-high reset sets `cs_n` high, `cmd` to NOP and `init_done` low, and returns the block to the wait state. `cs_n` is low from the first cycle after reset is released.
- R10: `cmd` is one-hot. Bit 0 is NOP, bit 1 is a mode-register write and bit 2 is an auto-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supplies are stable |
| clk_stable | input | 1 | Memory clock is stable |
| mode_word | input | ADDR_W | Mode value for the valid mode-register write |
| cmd | output | 3 | One-hot command: bit0 NOP, bit1 mode write, bit2 auto-refresh |
| bank | output | clog2(BANKS) | Bank address |
| addr | output | ADDR_W | Address bus |
| cs_n | output | 1 | Active-low chip-select |
| init_done | output | 1 | Initialization complete, held until reset |

## Verification
The assertions assume three things about the inputs. `mode_word` is held constant during the valid mode write. Reset is asserted from time zero for at least two cycles. Once `pwr_good` and `clk_stable` have been seen high together, the block ignores later changes to them.

The stimulus follows these assumptions. It changes `mode_word` only while reset is high. It starts every run with a multi-cycle reset. It holds both power inputs high from the start edge until the run ends or is cut short by reset. A zero mode word is also driven, so the assertion that a nonzero-address write must end the burst is exercised only on runs whose mode word is nonzero.

// File: rtl/dram_init_seq.sv
module dram_init_seq #(
  parameter int CLK_PS  = 20000,
  parameter int IDLE_NS = 200000,
  parameter int N_DUMMY = 2,
  parameter int T_MRSC  = 4,
  parameter int T_RC    = 6,
  parameter int NOP_PAD = 1024,
  parameter int ADDR_W  = 14,
  parameter int BANKS   = 8,
  localparam int BA_W   = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good,
  input  logic              clk_stable,
  input  logic [ADDR_W-1:0] mode_word,
  output logic [2:0]        cmd,
  output logic [BA_W-1:0]   bank,
  output logic [ADDR_W-1:0] addr,
  output logic              cs_n,
  output logic              init_done
);
  localparam int IDLE_CYC = (IDLE_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int PAD_LEN  = (NOP_PAD > T_RC) ? NOP_PAD : T_RC;
  localparam int M1   = (IDLE_CYC > PAD_LEN) ? IDLE_CYC : PAD_LEN;
  localparam int M2   = (M1 > BANKS) ? M1 : BANKS;
  localparam int MAXC = (M2 > N_DUMMY + T_MRSC) ? M2 : N_DUMMY + T_MRSC;
  localparam int CW   = $clog2(MAXC + 1);

  localparam logic [2:0] C_NOP  = 3'b001;
  localparam logic [2:0] C_MRS  = 3'b010;
  localparam logic [2:0] C_AREF = 3'b100;

  typedef enum logic [2:0] {S_WAIT, S_IDLE, S_MRS, S_SETTLE, S_REF, S_PAD, S_DONE} st_t;

  st_t         state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_WAIT;
      cnt   <= '0;
      cs_n  <= 1'b1;
    end else begin
      cs_n <= 1'b0;
      case (state)
        S_WAIT: if (pwr_good && clk_stable) begin
          state <= S_IDLE;
          cnt   <= '0;
        end
        S_IDLE: if (cnt == CW'(IDLE_CYC - 1)) begin
          state <= S_MRS;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        S_MRS: if (cnt == CW'(N_DUMMY)) begin
          state <= S_SETTLE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        S_SETTLE: if (cnt == CW'(T_MRSC - 2)) begin
          state <= S_REF;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        S_REF: if (cnt == CW'(BANKS - 1)) begin
          state <= S_PAD;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        S_PAD: if (cnt == CW'(PAD_LEN - 1)) begin
          state <= S_DONE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        default: state <= S_DONE;
      endcase
    end
  end

  assign cmd       = (state == S_MRS) ? C_MRS : (state == S_REF) ? C_AREF : C_NOP;
  assign bank      = (state == S_REF) ? cnt[BA_W-1:0] : '0;
  assign addr      = (state == S_MRS && cnt == CW'(N_DUMMY)) ? mode_word : '0;
  assign init_done = (state == S_DONE);
endmodule

module dram_init_seq_chk #(
  parameter int T_MRSC = 4,
  parameter int ADDR_W = 14,
  parameter int BANKS  = 8,
  localparam int BA_W  = $clog2(BANKS),
  localparam int SW    = $clog2(T_MRSC + 1) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_good,
  input logic              clk_stable,
  input logic [2:0]        cmd,
  input logic [BA_W-1:0]   bank,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);
  logic          seen_pwr;
  logic [SW-1:0] since_mrs;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_pwr  <= 1'b0;
      since_mrs <= SW'(T_MRSC);
    end else begin
      if (pwr_good && clk_stable) seen_pwr <= 1'b1;
      if (cmd[1]) since_mrs <= SW'(1);
      else if (since_mrs < SW'(T_MRSC)) since_mrs <= since_mrs + 1'b1;
    end
  end

  assert_nop_before_power_R1: assert property (@(posedge clk) disable iff (rst)
    !seen_pwr |-> cmd == 3'b001);
  assert_nonzero_mrs_is_last_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'b010 && addr != '0) |=> cmd != 3'b010);
  assert_settle_before_refresh_R5: assert property (@(posedge clk) disable iff (rst)
    cmd == 3'b100 |-> since_mrs >= SW'(T_MRSC));
  assert_banks_ascend_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'b100 && $past(cmd) == 3'b100) |-> bank == BA_W'($past(bank) + 1'b1));
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    $past(init_done) |-> init_done);
  assert_done_idle_bus_R8: assert property (@(posedge clk) disable iff (rst)
    init_done |-> cmd == 3'b001);
  assert_cmd_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $countones(cmd) == 1);
endmodule

bind dram_init_seq dram_init_seq_chk #(.T_MRSC(T_MRSC), .ADDR_W(ADDR_W), .BANKS(BANKS)) u_chk (
  .clk(clk), .rst(rst), .pwr_good(pwr_good), .clk_stable(clk_stable),
  .cmd(cmd), .bank(bank), .addr(addr), .init_done(init_done));

// File: tb/tb_dram_init_seq.sv
module tb_dram_init_seq;
  localparam int CLK_PS = 20000, IDLE_NS = 410, ND = 3, MRSC = 3, TRC = 6, PAD = 1024;
  localparam int AW = 14, NB = 8, BW = 3;
  localparam int IDLE_CYC = (IDLE_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int PAD_LEN  = (PAD > TRC) ? PAD : TRC;
  localparam int T_MRS  = IDLE_CYC;
  localparam int T_SET  = T_MRS + ND + 1;
  localparam int T_REF  = T_SET + MRSC - 1;
  localparam int T_PAD  = T_REF + NB;
  localparam int T_DONE = T_PAD + PAD_LEN;

  logic clk = 0, rst = 1, pwr_good = 0, clk_stable = 0;
  logic [AW-1:0] mode_word = '0;
  logic [2:0] cmd;
  logic [BW-1:0] bank;
  logic [AW-1:0] addr;
  logic cs_n, init_done;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10ns clk = ~clk;

  dram_init_seq #(.CLK_PS(CLK_PS), .IDLE_NS(IDLE_NS), .N_DUMMY(ND), .T_MRSC(MRSC),
    .T_RC(TRC), .NOP_PAD(PAD), .ADDR_W(AW), .BANKS(NB)) dut (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .clk_stable(clk_stable),
    .mode_word(mode_word), .cmd(cmd), .bank(bank), .addr(addr),
    .cs_n(cs_n), .init_done(init_done));

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(logic [AW-1:0] mw);
    @(negedge clk);
    rst = 1; pwr_good = 0; clk_stable = 0; mode_word = mw;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && cmd == 3'b001 && !init_done, "R9 reset",
        {cs_n, cmd, init_done}, {1'b1, 3'b001, 1'b0});
    rst = 0;
    @(negedge clk);
    chk(cs_n == 1'b0, "R9 cs_n after release", cs_n, 0);
  endtask

  task automatic run(logic [AW-1:0] mw, int pdelay, int abort_at);
    do_reset(mw);
    pwr_good = 1;
    for (int i = 0; i < pdelay; i++) begin
      @(negedge clk);
      chk(cmd == 3'b001 && !init_done, "R1 wait", cmd, 3'b001);
    end
    clk_stable = 1;
    for (int k = 0; k < T_DONE + 20; k++) begin
      logic [2:0] ec; logic [BW-1:0] eb; logic [AW-1:0] ea; logic ed; string rq;
      @(negedge clk);
      if (k == abort_at) begin
        rst = 1;
        @(negedge clk);
        chk(cs_n && cmd == 3'b001 && !init_done, "R9 mid-run reset",
            {cs_n, cmd, init_done}, {1'b1, 3'b001, 1'b0});
        rst = 0; pwr_good = 0; clk_stable = 0;
        repeat (5) begin
          @(negedge clk);
          chk(cmd == 3'b001 && !cs_n, "R1 wait after reset", cmd, 3'b001);
        end
        return;
      end
      ec = 3'b001; eb = '0; ea = '0; ed = 0;
      if (k < T_MRS) rq = "R2 idle";
      else if (k < T_SET) begin
        ec = 3'b010; rq = (k == T_SET - 1) ? "R3 valid mode" : "R4 dummy";
        if (k == T_SET - 1) ea = mw;
      end else if (k < T_REF) rq = "R5 settle";
      else if (k < T_PAD) begin
        ec = 3'b100; eb = BW'(k - T_REF); rq = "R6 refresh";
      end else if (k < T_DONE) rq = "R7 pad";
      else begin ed = 1; rq = "R8 done"; end
      chk(cmd == ec && bank == eb && addr == ea && init_done == ed && $onehot(cmd), rq,
          {cmd, bank, addr, init_done}, {ec, eb, ea, ed});
    end
  endtask

  initial begin
    run(14'h01A5, 0, -1);
    run(14'h3FFF, 7, -1);
    run(14'h0000, 2, -1);
    run(14'h2AB3, 4, T_REF + 3);
    run(14'h1234, 1, T_MRS + 1);
    run(14'h0A5A, 3, -1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule